// File: doc/BRIEF.md
# Diagnostic Fault Reporting Unit

This block merges the protection and diagnostic flags of a high-side power switch into one active-low, open-drain-style fault line. It watches the switch command, a current-limit request, an on-state undercurrent comparator, an off-state comparator that fires when the output sits close to the supply, and two thermal flags: absolute overtemperature and fast temperature swing. A diagnostic enable gates the whole report.

Each fault class has its own latch with its own set and clear rule. Both open-load comparators are deglitched, so a condition must last a programmable number of clock ticks before it is reported. A short to the supply looks the same as an open load to these comparators, so it takes the same path.

A report-holding timer keeps most faults alive through short low phases of the command. Under PWM dimming, the fault line therefore stays low as long as the fault persists. The fault line is released only when every latched class has met its own clear condition.

Top module: `fault_report_unit`

## Requirements
- R1: With no fault condition present, `fault_n` reads 1 after reset and stays 1 whether `cmd` is 0 or 1.
- R2: `climit_req` = 1 sampled at a clock edge while `cmd` = 1 drives `fault_n` to 0 after that edge. The fault clears at the first edge that samples `cmd` = 1 with `climit_req` = 0.
- R3: An on-state open load (`cmd` = 1 and `ol_on_cmp` = 1) is reported only after it has held for DEGLITCH_TICKS + 1 consecutive edges. Any gap restarts the count.
- R4: An on-state open-load fault clears at the first edge that samples `cmd` = 1 with `ol_on_cmp` = 0.
- R5: Current-limit, on-state open-load and thermal faults survive a `cmd` low phase of up to HOLD_TICKS edges. They clear when `cmd` stays 0 for HOLD_TICKS + 1 consecutive edges.
- R6: An off-state open load or short to supply (`cmd` = 0 and `ol_off_cmp` = 1) is reported after DEGLITCH_TICKS + 1 consecutive edges. It clears at a rising edge of `cmd`, or at the first edge that samples `cmd` = 0 with `ol_off_cmp` = 0. Holding `cmd` low does not clear it.
- R7: `tsd_flag` = 1 or `tsw_flag` = 1 sampled while `cmd` = 1 drives `fault_n` to 0 after that edge. That thermal class clears when its flag returns to 0, or by the hold expiry of R5.
- R8: While `diag_en` = 0, `fault_n` is 1 for every input pattern. All latched faults and deglitch counts are discarded, so re-enabling shows no stale fault and restarts deglitching.
- R9: With several classes latched, `fault_n` stays 0 until the last of them has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| diag_en | input | 1 | Diagnostic enable; 0 silences the report |
| cmd | input | 1 | Switch command, 1 = output on |
| climit_req | input | 1 | Current-limit fault request from the protection loop |
| ol_on_cmp | input | 1 | On-state load current below open-load threshold |
| ol_off_cmp | input | 1 | Off-state output voltage close to the supply |
| tsd_flag | input | 1 | Absolute overtemperature shutdown active |
| tsw_flag | input | 1 | Temperature swing shutdown active |
| fault_n | output | 1 | Fault report, active low |

## Verification
A latch stuck set shows up at once as `fault_n` held low after its clear event. A latch that never sets shows up as `fault_n` staying high one edge after a current-limit or thermal request. A deglitch or hold counter that is off by one moves the `fault_n` transition by exactly one edge, so the bench samples the cycle before and the cycle after each threshold. A toggle detector that misfires appears as an off-state fault that survives a rising `cmd`, or one that vanishes while `cmd` stays low.

// File: rtl/fault_rpt_pkg.sv
package fault_rpt_pkg;

    localparam int NCLS = 5;

    typedef enum int unsigned {
        CLS_CLIM  = 0,
        CLS_OLON  = 1,
        CLS_OLOFF = 2,
        CLS_TSD   = 3,
        CLS_TSW   = 4
    } fault_cls_e;

    typedef logic [NCLS-1:0] cls_vec_t;

    typedef struct packed {
        logic cmd;
        logic climit;
        logic ol_on;
        logic ol_off;
        logic tsd;
        logic tsw;
    } sense_t;

    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/fr_run_counter.sv
module fr_run_counter #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic run,
    output logic reached
);
    import fault_rpt_pkg::*;

    localparam int             W     = cnt_width(LIMIT);
    localparam logic [W-1:0]   LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || flush || !run)
            cnt <= '0;
        else if (cnt != LIM_V)
            cnt <= cnt + 1'b1;
    end

    assign reached = run && (cnt == LIM_V);
endmodule

// File: rtl/fr_class_latch.sv
module fr_class_latch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || !enable)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end
endmodule

// File: rtl/fault_report_unit.sv
module fault_report_unit #(
    parameter int DEGLITCH_TICKS = 15000,
    parameter int HOLD_TICKS     = 425000
) (
    input  logic clk,
    input  logic rst,
    input  logic diag_en,
    input  logic cmd,
    input  logic climit_req,
    input  logic ol_on_cmp,
    input  logic ol_off_cmp,
    input  logic tsd_flag,
    input  logic tsw_flag,
    output logic fault_n
);
    import fault_rpt_pkg::*;

    sense_t   sn;
    cls_vec_t set_v, clr_v, lat_q;
    logic     cmd_q, cmd_rise, hold_exp, olon_ok, oloff_ok;

    assign sn = '{cmd: cmd, climit: climit_req, ol_on: ol_on_cmp,
                  ol_off: ol_off_cmp, tsd: tsd_flag, tsw: tsw_flag};

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= 1'b0;
        else     cmd_q <= sn.cmd;
    end
    assign cmd_rise = sn.cmd && !cmd_q;

    // command-low duration for report holding
    fr_run_counter #(.LIMIT(HOLD_TICKS)) u_hold (
        .clk(clk), .rst(rst), .flush(1'b0),
        .run(!sn.cmd), .reached(hold_exp)
    );

    // open-load qualification in both output states
    fr_run_counter #(.LIMIT(DEGLITCH_TICKS)) u_dg_on (
        .clk(clk), .rst(rst), .flush(!diag_en),
        .run(sn.cmd && sn.ol_on), .reached(olon_ok)
    );
    fr_run_counter #(.LIMIT(DEGLITCH_TICKS)) u_dg_off (
        .clk(clk), .rst(rst), .flush(!diag_en),
        .run(!sn.cmd && sn.ol_off), .reached(oloff_ok)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[CLS_CLIM]  = sn.cmd && sn.climit;
        clr_v[CLS_CLIM]  = (sn.cmd && !sn.climit) || hold_exp;
        set_v[CLS_OLON]  = olon_ok;
        clr_v[CLS_OLON]  = (sn.cmd && !sn.ol_on) || hold_exp;
        set_v[CLS_OLOFF] = oloff_ok;
        clr_v[CLS_OLOFF] = cmd_rise || (!sn.cmd && !sn.ol_off);
        set_v[CLS_TSD]   = sn.cmd && sn.tsd;
        clr_v[CLS_TSD]   = !sn.tsd || hold_exp;
        set_v[CLS_TSW]   = sn.cmd && sn.tsw;
        clr_v[CLS_TSW]   = !sn.tsw || hold_exp;
    end

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        fr_class_latch u_lat (
            .clk(clk), .rst(rst), .enable(diag_en),
            .set(set_v[i]), .clr(clr_v[i]), .q(lat_q[i])
        );
    end

    assign fault_n = !(diag_en && (|lat_q));
endmodule

// File: rtl/fault_report_unit_chk.sv
module fault_report_unit_chk (
    input logic                          clk,
    input logic                          rst,
    input logic                          diag_en,
    input logic                          cmd,
    input logic                          climit_req,
    input logic                          tsd_flag,
    input logic                          fault_n,
    input fault_rpt_pkg::cls_vec_t       lat
);
    import fault_rpt_pkg::*;

    p_clim_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (diag_en && cmd && climit_req) |=> !fault_n);

    p_olon_needs_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd |=> !$rose(lat[CLS_OLON]));

    p_clim_survives_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmd) && diag_en && lat[CLS_CLIM]) |=> lat[CLS_CLIM]);

    p_oloff_toggle_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd) |=> !lat[CLS_OLOFF]);

    p_tsd_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (diag_en && cmd && tsd_flag) |=> !fault_n);

    p_disable_flush_r8: assert property (@(posedge clk) disable iff (rst)
        !diag_en |=> (lat == '0));
endmodule

bind fault_report_unit fault_report_unit_chk u_chk (
    .clk(clk), .rst(rst), .diag_en(diag_en), .cmd(cmd),
    .climit_req(climit_req), .tsd_flag(tsd_flag),
    .fault_n(fault_n), .lat(lat_q)
);

// File: tb/sim_fault_report_unit.sv
module sim_fault_report_unit;
    localparam int DG   = 20;
    localparam int HOLD = 50;

    logic clk = 1'b0;
    logic rst, diag_en, cmd, climit_req, ol_on_cmp, ol_off_cmp, tsd_flag, tsw_flag;
    logic fault_n;
    int   n_run  = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    fault_report_unit #(.DEGLITCH_TICKS(DG), .HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst(rst), .diag_en(diag_en), .cmd(cmd),
        .climit_req(climit_req), .ol_on_cmp(ol_on_cmp), .ol_off_cmp(ol_off_cmp),
        .tsd_flag(tsd_flag), .tsw_flag(tsw_flag), .fault_n(fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        n_run++;
        if (fault_n !== exp) begin
            n_fail++;
            $display("FAIL %s: fault_n=%b expected=%b", tag, fault_n, exp);
        end
    endtask

    task automatic restart();
        rst = 1'b1; diag_en = 1'b1; cmd = 1'b0; climit_req = 1'b0;
        ol_on_cmp = 1'b0; ol_off_cmp = 1'b0; tsd_flag = 1'b0; tsw_flag = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_idle();
        restart();
        chk(1'b1, "R1 after reset");
        cmd = 1'b1; step(5);
        chk(1'b1, "R1 cmd high no fault");
        cmd = 1'b0; step(5);
        chk(1'b1, "R1 cmd low no fault");
    endtask

    task automatic t_climit();
        restart();
        cmd = 1'b1; climit_req = 1'b1; step(1);
        chk(1'b0, "R2 current limit sets");
        step(3);
        chk(1'b0, "R2 current limit persists");
        climit_req = 1'b0; step(1);
        chk(1'b1, "R2 request removed clears");
    endtask

    task automatic t_olon();
        restart();
        cmd = 1'b1; ol_on_cmp = 1'b1; step(DG);
        chk(1'b1, "R3 before deglitch");
        step(1);
        chk(1'b0, "R3 after deglitch");
        ol_on_cmp = 1'b0; step(1);
        chk(1'b1, "R4 open load removed clears");
        ol_on_cmp = 1'b1; step(DG);
        ol_on_cmp = 1'b0; step(1);
        ol_on_cmp = 1'b1; step(DG);
        chk(1'b1, "R3 gap restarts deglitch");
        step(1);
        chk(1'b0, "R3 sets after restart");
        cmd = 1'b0; step(HOLD);
        chk(1'b0, "R5 olon held through hold window");
        step(1);
        chk(1'b1, "R5 olon cleared after hold expiry");
    endtask

    task automatic t_hold();
        restart();
        cmd = 1'b1; climit_req = 1'b1; step(1);
        cmd = 1'b0; climit_req = 1'b0; step(HOLD);
        chk(1'b0, "R5 low pulse of HOLD edges keeps fault");
        cmd = 1'b1; climit_req = 1'b1; step(1);
        chk(1'b0, "R5 fault continuous over gap");
        cmd = 1'b0; climit_req = 1'b0; step(HOLD + 1);
        chk(1'b1, "R5 low beyond hold clears");
    endtask

    task automatic t_oloff();
        restart();
        ol_off_cmp = 1'b1; step(DG);
        chk(1'b1, "R6 before deglitch");
        step(1);
        chk(1'b0, "R6 after deglitch");
        step(HOLD + 5);
        chk(1'b0, "R6 long low does not clear");
        cmd = 1'b1; step(1);
        chk(1'b1, "R6 toggle clears");
        step(DG + 5);
        chk(1'b1, "R6 no report while cmd high");
        cmd = 1'b0; step(DG + 1);
        chk(1'b0, "R6 short to supply reported again");
        ol_off_cmp = 1'b0; step(1);
        chk(1'b1, "R6 condition removed clears");
    endtask

    task automatic t_thermal();
        restart();
        cmd = 1'b1; tsd_flag = 1'b1; step(1);
        chk(1'b0, "R7 shutdown sets");
        tsd_flag = 1'b0; step(1);
        chk(1'b1, "R7 shutdown ends clears");
        tsw_flag = 1'b1; step(1);
        chk(1'b0, "R7 swing sets");
        cmd = 1'b0; step(HOLD);
        chk(1'b0, "R7 swing held within hold");
        step(1);
        chk(1'b1, "R7 swing cleared by hold expiry");
    endtask

    task automatic t_disable();
        restart();
        diag_en = 1'b0; cmd = 1'b1; climit_req = 1'b1; tsd_flag = 1'b1; step(3);
        chk(1'b1, "R8 disabled masks faults");
        climit_req = 1'b0; tsd_flag = 1'b0; ol_on_cmp = 1'b1; step(DG - 5);
        diag_en = 1'b1; step(6);
        chk(1'b1, "R8 deglitch restarted on enable");
        step(DG - 6);
        chk(1'b1, "R8 deglitch not yet met");
        step(1);
        chk(1'b0, "R8 deglitch met after enable");
        ol_on_cmp = 1'b0; step(1);
        tsw_flag = 1'b1; step(1);
        cmd = 1'b0; step(1);
        chk(1'b0, "R8 swing latched");
        diag_en = 1'b0; step(1);
        chk(1'b1, "R8 disabled output high");
        diag_en = 1'b1; step(1);
        chk(1'b1, "R8 latch discarded");
    endtask

    task automatic t_multi();
        restart();
        cmd = 1'b1; climit_req = 1'b1; tsd_flag = 1'b1; step(1);
        chk(1'b0, "R9 two faults set");
        climit_req = 1'b0; step(1);
        chk(1'b0, "R9 one class still active");
        tsd_flag = 1'b0; step(1);
        chk(1'b1, "R9 all classes cleared");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_idle();
        t_climit();
        t_olon();
        t_hold();
        t_oloff();
        t_thermal();
        t_disable();
        t_multi();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule